// File: doc/BRIEF.md
# Capture Counter with FIFO

This block is an event counter that advances once per clock in which its count-enable input is high. It counts up or down against a programmable period, compares the live count with a programmable value through a selectable operator, and emits a one-cycle terminal-count pulse whenever the count wraps. Four run modes decide what happens at the terminal value and whether the hardware reset input is honoured. The modes are free-running, reload-on-reset, halt-at-terminal and single-shot.

A capture input is resynchronised through two flops and edge-detected. Each rising edge pushes the count into a four-entry FIFO, which the host drains through a simple register port. A capture that finds the FIFO full is discarded and raises a sticky overflow flag. Three interrupt sources are terminal count, compare true and capture. Each latches a pending bit, and the masked pending bits are ORed into one level request.

Top module: `cap_counter`

## Requirements
- R1: After reset the count is 0, the period is all ones, the compare value is 0, the operator is less-than, the mode is free-running (code 0), counting is up, the interrupt mask is 0, the counter is running, the FIFO is empty, and tc_out, cmp_out and irq are low.
- R2: When counting up, each clock with en high and the counter running adds one. A step taken at a count greater than or equal to the period loads 0 and drives tc_out high for exactly the following cycle. With en low the count holds.
- R3: When counting down (control bit 5 set), each step subtracts one. A step taken at count 0 loads the period and pulses tc_out. The start value is the period when counting down and 0 when counting up.
- R4: cmp_out compares count against the compare value using control bits [2:0]. The codes are 0 for less-than, 1 for less-or-equal, 2 for greater-than, 3 for greater-or-equal and 4 for equal. Codes 5 to 7 give 0.
- R5: In free-running mode (control bits [4:3] = 0), a wrap reloads the start value and cnt_rst has no effect.
- R6: In reload-on-reset mode (code 1), a wrap reloads the start value. A cycle with cnt_rst high loads the start value and leaves the counter running.
- R7: In halt mode (code 2), the step at the terminal value pulses tc_out, keeps the count and stops the counter. cnt_rst then reloads the start value and restarts it.
- R8: In single-shot mode (code 3), the step at the terminal value pulses tc_out, loads the start value and stops the counter. Either cnt_rst or any write to address 6 restarts the counter from the start value.
- R9: A rising edge on cap_in pushes the count into the FIFO once, however long the input stays high. A read at address 5 with rd_en returns the oldest entry and removes it. A read of an empty FIFO returns 0.
- R10: A capture that arrives with four entries held is dropped and sets the overflow flag (status bit 3). The flag stays set until a status write with bit 3 set.
- R11: Pending bits in status [2:0] are set by terminal count (bit 0), compare true (bit 1) and capture (bit 2). A status write clears the bits written as 1. irq is high while any pending bit is enabled in the mask register (address 3, same bit order).
- R12: Address map: 0 period, 1 compare value, 2 control, 3 mask, 4 status, 5 FIFO pop, 6 count (a write restarts). The status fields are bits [2:0] pending, bit 3 overflow, bit 4 running and bits [7:5] FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable, one step per clock while high |
| cnt_rst | input | 1 | Hardware reload request, honoured by mode |
| cap_in | input | 1 | Asynchronous capture request, rising edge active |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_en | input | 1 | Read strobe, pops the FIFO at address 5 |
| rd_addr | input | 3 | Register read address |
| rd_data | output | WIDTH | Read data, combinational from rd_addr |
| cmp_out | output | 1 | Compare result |
| tc_out | output | 1 | One-cycle terminal-count pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong count or a wrong reload shows on the count register at once and shifts the next tc_out pulse by the same number of cycles. A stuck running flag appears in status bit 4 on the next read. A FIFO pointer error surfaces on the first pop as a value out of order or a level that disagrees with the bench model. A pending bit that fails to set or to clear shows on irq one cycle after the causing edge or the clearing write.

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cnt_rst,
  input  logic             cap_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [2:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             cmp_out,
  output logic             tc_out,
  output logic             irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [1:0] M_FREE = 2'd0, M_STOP = 2'd2, M_SHOT = 2'd3;

  logic [WIDTH-1:0] period_q, cmpv_q, count_q;
  logic [2:0]       op_q, mask_q, pend_q;
  logic [1:0]       mode_q;
  logic             down_q, running_q, tc_q, ovf_q;
  logic [2:0]       cap_sync;
  logic [WIDTH-1:0] fifo_q [DEPTH];
  logic [PW-1:0]    wptr_q, rptr_q;
  logic [LW-1:0]    level_q;

  logic restart, hw_reload, step, at_term, wrap, cap_rise, pop, full, push, drop;
  logic [WIDTH-1:0] start_val;

  assign restart   = wr_en && wr_addr == 3'd6;
  assign hw_reload = cnt_rst && mode_q != M_FREE;
  assign step      = en && running_q && !restart && !hw_reload;
  assign start_val = down_q ? period_q : '0;
  assign at_term   = down_q ? (count_q == '0) : (count_q >= period_q);
  assign wrap      = step && at_term;
  assign cap_rise  = cap_sync[1] && !cap_sync[2];
  assign pop       = rd_en && rd_addr == 3'd5 && level_q != '0;
  assign full      = level_q == LW'(DEPTH);
  assign push      = cap_rise && (!full || pop);
  assign drop      = cap_rise && full && !pop;
  assign tc_out    = tc_q;
  assign irq       = |(pend_q & mask_q);

  always_comb begin
    case (op_q)
      3'd0:    cmp_out = count_q <  cmpv_q;
      3'd1:    cmp_out = count_q <= cmpv_q;
      3'd2:    cmp_out = count_q >  cmpv_q;
      3'd3:    cmp_out = count_q >= cmpv_q;
      3'd4:    cmp_out = count_q == cmpv_q;
      default: cmp_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      running_q <= 1'b1;
      tc_q      <= 1'b0;
    end else begin
      tc_q <= wrap;
      if (restart || hw_reload) begin
        count_q   <= start_val;
        running_q <= 1'b1;
      end else if (step) begin
        if (at_term) begin
          if (mode_q != M_STOP) count_q <= start_val;
          if (mode_q == M_STOP || mode_q == M_SHOT) running_q <= 1'b0;
        end else begin
          count_q <= down_q ? count_q - 1'b1 : count_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      cmpv_q   <= '0;
      op_q     <= 3'd0;
      mode_q   <= M_FREE;
      down_q   <= 1'b0;
      mask_q   <= 3'd0;
      pend_q   <= 3'd0;
      ovf_q    <= 1'b0;
      cap_sync <= 3'd0;
    end else begin
      cap_sync <= {cap_sync[1:0], cap_in};
      if (wr_en && wr_addr == 3'd0) period_q <= wr_data;
      if (wr_en && wr_addr == 3'd1) cmpv_q <= wr_data;
      if (wr_en && wr_addr == 3'd2) begin
        op_q   <= wr_data[2:0];
        mode_q <= wr_data[4:3];
        down_q <= wr_data[5];
      end
      if (wr_en && wr_addr == 3'd3) mask_q <= wr_data[2:0];
      pend_q <= (pend_q & ~((wr_en && wr_addr == 3'd4) ? wr_data[2:0] : 3'd0))
              | {cap_rise, cmp_out, wrap};
      ovf_q  <= (ovf_q && !(wr_en && wr_addr == 3'd4 && wr_data[3])) || drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      level_q <= level_q + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo_q[wptr_q] <= count_q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      3'd0: rd_data = period_q;
      3'd1: rd_data = cmpv_q;
      3'd2: begin
        rd_data[2:0] = op_q;
        rd_data[4:3] = mode_q;
        rd_data[5]   = down_q;
      end
      3'd3: rd_data[2:0] = mask_q;
      3'd4: begin
        rd_data[2:0]    = pend_q;
        rd_data[3]      = ovf_q;
        rd_data[4]      = running_q;
        rd_data[5 +: LW] = level_q;
      end
      3'd5: if (level_q != '0) rd_data = fifo_q[rptr_q];
      3'd6: rd_data = count_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cap_counter_chk.sv
module cap_counter_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  parameter int LW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tc_out,
  input logic [2:0]       pend_q,
  input logic             ovf_q,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [LW-1:0]    level_q,
  input logic             cap_rise,
  input logic             pop,
  input logic             running_q,
  input logic [1:0]       mode_q,
  input logic [WIDTH-1:0] count_q,
  input logic             restart,
  input logic             cnt_rst
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !(wr_en && wr_addr == 3'd4 && wr_data[3]) |=> ovf_q); // R10
  AST_TC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> pend_q[0]); // R11
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'd2 && !running_q && !restart && !cnt_rst |=> $stable(count_q)); // R7
  AST_SHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'd3 && tc_out |-> !running_q); // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise && level_q < LW'(DEPTH) && !pop |=> level_q == $past(level_q) + 1'b1); // R9
endmodule

bind cap_counter cap_counter_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tc_out(tc_out), .pend_q(pend_q), .ovf_q(ovf_q),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .level_q(level_q),
  .cap_rise(cap_rise), .pop(pop), .running_q(running_q), .mode_q(mode_q),
  .count_q(count_q), .restart(restart), .cnt_rst(cnt_rst)
);

// File: tb/tb_cap_counter.sv
`timescale 1ns/1ps
module tb_cap_counter;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, en = 0, cnt_rst = 0, cap_in = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] rd_data;
  logic cmp_out, tc_out, irq;

  cap_counter #(.WIDTH(W), .DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt_rst(cnt_rst), .cap_in(cap_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_out(cmp_out), .tc_out(tc_out), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, mlvl = 0, v;
  int exp_q[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = a[2:0]; wr_data = d[W-1:0];
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(int a, output int r);
    @(negedge clk); rd_addr = a[2:0]; #1; r = int'(rd_data);
  endtask

  task automatic steps(int n);
    @(negedge clk); en = 1;
    repeat (n) @(negedge clk);
    en = 0;
  endtask

  task automatic pulse_rst();
    @(negedge clk); cnt_rst = 1;
    @(negedge clk); cnt_rst = 0;
  endtask

  task automatic capture(int val);
    @(negedge clk); cap_in = 1;
    repeat (4) @(negedge clk);
    cap_in = 0;
    repeat (3) @(negedge clk);
    if (mlvl < 4) begin exp_q.push_back(val); mlvl++; end
  endtask

  task automatic pop_one();
    @(negedge clk); rd_addr = 3'd5; rd_en = 1;
    @(negedge clk); rd_en = 0;
    if (mlvl > 0) mlvl--;
  endtask

  always begin
    @(negedge clk); #1;
    if (rd_en && rd_addr == 3'd5) begin
      int e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
      chk("R9 fifo pop", int'(rd_data), e);
    end
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek(6, v); chk("R1 count", v, 0);
    peek(0, v); chk("R1 period", v, 255);
    peek(4, v); chk("R12 status after reset", v, 16);
    chk("R1 tc_out", tc_out, 0); chk("R1 irq", irq, 0); chk("R1 cmp_out", cmp_out, 0);

    wr(0, 5);
    steps(3); peek(6, v); chk("R2 up count", v, 3);
    repeat (2) @(negedge clk); peek(6, v); chk("R2 hold with en low", v, 3);
    steps(2); chk("R2 no tc before wrap", tc_out, 0);
    steps(1); chk("R2 tc pulse", tc_out, 1);
    peek(6, v); chk("R2 wrap to 0", v, 0);
    chk("R2 tc one cycle", tc_out, 0);

    steps(2); wr(1, 2);
    wr(2, 0); chk("R4 LT at equal", cmp_out, 0);
    wr(2, 1); chk("R4 LE", cmp_out, 1);
    wr(2, 2); chk("R4 GT", cmp_out, 0);
    wr(2, 3); chk("R4 GE", cmp_out, 1);
    wr(2, 4); chk("R4 EQ", cmp_out, 1);
    wr(2, 5); chk("R4 unused code", cmp_out, 0);
    wr(1, 3); wr(2, 0); chk("R4 LT below", cmp_out, 1);
    wr(1, 0); chk("R4 LT false", cmp_out, 0);

    pulse_rst(); peek(6, v); chk("R5 cnt_rst ignored", v, 2);
    wr(2, 8); pulse_rst(); peek(6, v); chk("R6 reload", v, 0);

    wr(2, 40); pulse_rst(); peek(6, v); chk("R3 down start", v, 5);
    steps(2); peek(6, v); chk("R3 down count", v, 3);
    steps(3); peek(6, v); chk("R3 down reach 0", v, 0);
    steps(1); chk("R3 tc on down wrap", tc_out, 1);
    peek(6, v); chk("R3 reload period", v, 5);

    wr(2, 16); pulse_rst(); peek(6, v); chk("R7 start", v, 0);
    steps(5); peek(6, v); chk("R7 reach period", v, 5);
    steps(1); chk("R7 tc at halt", tc_out, 1);
    steps(2); peek(6, v); chk("R7 held", v, 5);
    peek(4, v); chk("R7 stopped", (v >> 4) & 1, 0);
    pulse_rst(); peek(6, v); chk("R7 resume value", v, 0);
    peek(4, v); chk("R7 running again", (v >> 4) & 1, 1);

    wr(2, 24); pulse_rst();
    steps(5); steps(1); chk("R8 tc", tc_out, 1);
    steps(3); peek(6, v); chk("R8 stopped at start", v, 0);
    peek(4, v); chk("R8 not running", (v >> 4) & 1, 0);
    wr(6, 0); steps(2); peek(6, v); chk("R8 sw restart", v, 2);

    wr(2, 0);
    capture(2); steps(1); capture(3);
    peek(4, v); chk("R9 level after two captures", (v >> 5) & 7, 2);
    pop_one(); pop_one(); pop_one();

    for (int i = 0; i < 5; i++) capture(3);
    peek(4, v); chk("R10 level full", (v >> 5) & 7, 4);
    chk("R10 overflow set", (v >> 3) & 1, 1);
    for (int i = 0; i < 4; i++) pop_one();
    peek(4, v); chk("R10 overflow sticky", (v >> 3) & 1, 1);
    wr(4, 8); peek(4, v); chk("R10 overflow cleared", (v >> 3) & 1, 0);

    wr(4, 7); peek(4, v); chk("R11 pending cleared", v & 7, 0);
    chk("R11 irq low", irq, 0);
    wr(3, 4); steps(3); peek(4, v); chk("R11 tc pending", v & 7, 1);
    chk("R11 masked tc no irq", irq, 0);
    capture(0); chk("R11 capture irq", irq, 1);
    wr(4, 4); chk("R11 cleared irq", irq, 0);
    peek(4, v); chk("R11 tc still pending", v & 7, 1);
    pop_one();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule